// File: doc/BRIEF.md
# Input Power and Snapshot Monitor

This block watches a single stream of signed samples. For every sync interval it sums the squares of the valid samples into a wide accumulator. When the next sync sample arrives, that sum moves into a readable power register. At the same sync the block also records the following run of consecutive valid samples into a capture buffer. Software can read the buffer one word per sample.

The sync marker comes from an upstream block-framing source. The marker flags the first sample of each interval, and it counts only when the sample is valid. Two read ports serve the results, each with one cycle of read latency. A register port returns the latched power as two 32-bit words. A buffer port returns captured samples, sign-extended to 32 bits. Reading the low power word saves a copy of the high word, so a low-then-high read pair always describes the same interval.

Top module: `pwr_snap_monitor`

## Requirements
- R1: After reset, `reg_rdata` and `buf_rdata` are zero, and the power words read back as zero until the first sync sample has been accepted.
- R2: Only samples with `smp_vld` high are squared and added; the data on cycles with `smp_vld` low has no effect. On a valid sample with `smp_sync` high, the sum of the squares accepted since the previous sync moves into the power register, and the accumulator restarts with the square of that sync sample.
- R3: The accumulator of `ACC_W` bits saturates at 2^ACC_W-1 instead of wrapping; with `ACC_W`=34, twenty samples of -32768 read back as 0x3_FFFFFFFF.
- R4: A read on `reg_addr` 2 returns bits [31:0] of the power register, and a read on `reg_addr` 3 returns bits [63:32]. Addresses 0 and 1 return zero. `reg_rdata` is valid in the cycle after `reg_rd`, and it holds its value while `reg_rd` is low.
- R5: A valid sync sample is written to buffer word 0, and the next `SNAP_DEPTH`-1 valid samples fill words 1 onward in arrival order.
- R6: Once `SNAP_DEPTH` samples are stored, the buffer stays frozen until the next valid sync sample; later samples do not change it.
- R7: A buffer read returns the stored sample in bits [15:0], sign-extended into bits [31:16]. It is valid in the cycle after `buf_rd`, and `buf_rdata` holds its value while `buf_rd` is low.
- R8: `smp_sync` high while `smp_vld` is low is ignored: it restarts neither the capture nor the accumulation, and it does not latch the power register.
- R9: For a sine of amplitude A spread over N valid samples in one interval, the latched power lies within 5% of A²/2·N.
- R10: A read of address 3 returns the high word that was copied at the most recent address-2 read, even when a sync has updated the power register between those two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample qualifier |
| smp_sync | input | 1 | Marks the first sample of an interval (qualified by smp_vld) |
| smp_data | input | SMP_W | Signed sample value |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word offset |
| reg_rdata | output | REG_W | Register read data, one cycle after reg_rd |
| buf_rd | input | 1 | Capture buffer read strobe |
| buf_addr | input | BUF_AW | Capture buffer word index |
| buf_rdata | output | REG_W | Sign-extended sample, one cycle after buf_rd |

## Verification
The design registers every read result, so register and buffer data are due exactly one clock edge after the edge that sampled the strobe. The bench registers each strobe on the rising edge and compares on the falling edge that follows, taking the expected item from the head of a queue. A sync sample changes the power register on its own edge, so a read issued on the next cycle must already return the new value. The bench model updates its expected sums when it drives that sample, which keeps the expected value and the read in step. A capture written on one edge is readable from the next cycle, so the buffer readback runs at full rate right after stimulus stops.

// File: rtl/pwrmon_pkg.sv
package pwrmon_pkg;

    // Word offsets on the register read port; the power word positions are fixed.
    typedef enum logic [1:0] {
        OFS_RSVD0  = 2'd0,
        OFS_RSVD1  = 2'd1,
        OFS_PWR_LO = 2'd2,
        OFS_PWR_HI = 2'd3
    } reg_ofs_e;

    localparam int REG_ADDR_W = 2;

endpackage

// File: rtl/pwrmon_accum.sv
module pwrmon_accum #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic                    smp_sync,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic [ACC_W-1:0]        pwr_lat
);

    localparam int SQ_W  = 2 * SMP_W;
    localparam int PAD_W = ACC_W + 1 - SQ_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] lat;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic signed [SQ_W-1:0] sq_s;
    logic [ACC_W:0]         sq_x;
    logic [ACC_W:0]         sum_x;

    always_comb begin
        sq_s  = smp_data * smp_data;
        sq_x  = {{PAD_W{1'b0}}, sq_s};
        sum_x = {1'b0, st_q.acc} + sq_x;
        st_d  = st_q;
        if (smp_vld) begin
            if (smp_sync) begin
                st_d.lat = st_q.acc;
                st_d.acc = sq_x[ACC_W-1:0];
            end else if (sum_x[ACC_W]) begin
                st_d.acc = '1;
            end else begin
                st_d.acc = sum_x[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_lat = st_q.lat;

    // R3: a running sum never moves down between syncs
    a_r3_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !smp_sync) |=> (st_q.acc >= $past(st_q.acc)));

    // R3: once at full scale it stays there until a sync
    a_r3_sat_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !smp_sync && (st_q.acc == '1)) |=> (st_q.acc == '1));

    // R2, R8: the latched power changes only on a valid sync sample
    a_r2_lat_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && smp_sync) |=> $stable(st_q.lat));

    // R2: invalid cycles leave the running sum untouched
    a_r2_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(st_q.acc));

endmodule

// File: rtl/pwrmon_snap.sv
module pwrmon_snap #(
    parameter int SMP_W = 16,
    parameter int DEPTH = 1024,
    parameter int REG_W = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             smp_sync,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             buf_rd,
    input  logic [AW-1:0]    buf_addr,
    output logic [REG_W-1:0] buf_rdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic             active;
        logic [AW-1:0]    ptr;
        logic [REG_W-1:0] rdata;
    } snap_st_t;

    snap_st_t st_d, st_q;

    logic [SMP_W-1:0] mem [DEPTH];
    logic             we;
    logic [AW-1:0]    wa;
    logic [SMP_W-1:0] rd_smp;

    always_comb begin
        st_d   = st_q;
        we     = 1'b0;
        wa     = st_q.ptr;
        rd_smp = mem[buf_addr];
        if (smp_vld) begin
            if (smp_sync) begin
                we        = 1'b1;
                wa        = '0;
                st_d.ptr  = AW'(1);
                st_d.active = 1'b1;
            end else if (st_q.active) begin
                we       = 1'b1;
                st_d.ptr = st_q.ptr + AW'(1);
                if (st_q.ptr == LAST) begin
                    st_d.active = 1'b0;
                    st_d.ptr    = '0;
                end
            end
        end
        if (buf_rd) begin
            st_d.rdata = {{(REG_W - SMP_W){rd_smp[SMP_W-1]}}, rd_smp};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= smp_data;
    end

    assign buf_rdata = st_q.rdata;

    // R5: a valid sync starts a capture at word 0
    a_r5_restart : assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_sync) |=> (st_q.active && (st_q.ptr == AW'(1))));

    // R6: a finished capture stays frozen until a valid sync
    a_r6_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !(smp_vld && smp_sync)) |=> (!st_q.active && $stable(st_q.ptr)));

    // R8: a sync without a valid sample does not start a capture
    a_r8_sync_needs_vld : assert property (@(posedge clk) disable iff (!rst_n)
        (smp_sync && !smp_vld && !st_q.active) |=> !st_q.active);

    // R7: read data holds while no read is requested
    a_r7_rd_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !buf_rd |=> $stable(buf_rdata));

endmodule

// File: rtl/pwrmon_regs.sv
module pwrmon_regs
    import pwrmon_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int REG_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [ACC_W-1:0]      pwr_lat,
    output logic [REG_W-1:0]      reg_rdata
);

    localparam int WIDE_W = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] hold;
        logic [REG_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide              = '0;
        wide[ACC_W-1:0]   = pwr_lat;
        st_d              = st_q;
        if (reg_rd) begin
            case (reg_ofs_e'(reg_addr))
                OFS_PWR_LO: begin
                    st_d.rdata = wide[REG_W-1:0];
                    st_d.hold  = wide[WIDE_W-1:REG_W];
                end
                OFS_PWR_HI: st_d.rdata = st_q.hold;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    // R4: read data holds while no read is requested
    a_r4_rd_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R10: the saved high word changes only on a low-word read
    a_r10_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && (reg_addr == OFS_PWR_LO)) |=> $stable(st_q.hold));

    // R4: reserved offsets read as zero
    a_r4_rsvd_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr < OFS_PWR_LO)) |=> (reg_rdata == '0));

endmodule

// File: rtl/pwr_snap_monitor.sv
module pwr_snap_monitor
    import pwrmon_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int ACC_W      = 64,
    parameter int SNAP_DEPTH = 1024,
    parameter int REG_W      = 32,
    localparam int BUF_AW    = $clog2(SNAP_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic                  smp_sync,
    input  logic [SMP_W-1:0]      smp_data,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  buf_rd,
    input  logic [BUF_AW-1:0]     buf_addr,
    output logic [REG_W-1:0]      buf_rdata
);

    logic [ACC_W-1:0] pwr_lat;

    pwrmon_accum #(
        .SMP_W (SMP_W),
        .ACC_W (ACC_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_sync (smp_sync),
        .smp_data (signed'(smp_data)),
        .pwr_lat  (pwr_lat)
    );

    pwrmon_snap #(
        .SMP_W (SMP_W),
        .DEPTH (SNAP_DEPTH),
        .REG_W (REG_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_sync  (smp_sync),
        .smp_data  (smp_data),
        .buf_rd    (buf_rd),
        .buf_addr  (buf_addr),
        .buf_rdata (buf_rdata)
    );

    pwrmon_regs #(
        .ACC_W (ACC_W),
        .REG_W (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .pwr_lat   (pwr_lat),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/tb_pwr_snap_monitor.sv
`timescale 1ns/1ps
module tb_pwr_snap_monitor;

    localparam int         DEPTH  = 1024;
    localparam longint     SATMAX = 64'h3_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        smp_sync = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        buf_rd = 1'b0;
    logic [9:0]  buf_addr = '0;
    logic [31:0] reg_rdata, buf_rdata, sat_rdata, sat_buf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_snap_monitor dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_sync(smp_sync),
        .smp_data(smp_data), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata)
    );

    pwr_snap_monitor #(.ACC_W(34)) dut_sat (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_sync(smp_sync),
        .smp_data(smp_data), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_rdata(sat_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr),
        .buf_rdata(sat_buf)
    );

    // expected-value model built from the requirements
    longint unsigned acc_m = 0, lat_m = 0, acc_s = 0, lat_s = 0;
    logic [31:0]     hold_m = '0, hold_s = '0;
    logic [15:0]     ref_buf [DEPTH];
    bit              snap_on = 1'b0;
    int              snap_ptr = 0;
    logic [31:0]     last_word [4];

    typedef struct {
        int          kind;
        int          addr;
        logic [31:0] exp;
        logic [31:0] exp2;
        string       tag;
    } item_t;
    item_t q[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic smp(input bit v, input bit s, input logic [15:0] d);
        longint unsigned sq;
        @(negedge clk);
        smp_vld = v; smp_sync = s; smp_data = d;
        reg_rd = 1'b0; buf_rd = 1'b0;
        if (v) begin
            sq = longint'($signed(d)) * longint'($signed(d));
            if (s) begin
                lat_m = acc_m; lat_s = acc_s;
                acc_m = sq; acc_s = sq;
                ref_buf[0] = d; snap_on = 1'b1; snap_ptr = 1;
            end else begin
                acc_m = acc_m + sq;
                acc_s = (acc_s + sq > SATMAX) ? SATMAX : acc_s + sq;
                if (snap_on) begin
                    ref_buf[snap_ptr] = d;
                    snap_ptr++;
                    if (snap_ptr == DEPTH) snap_on = 1'b0;
                end
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        smp_vld = 1'b0; smp_sync = 1'b0; reg_rd = 1'b0; buf_rd = 1'b0;
    endtask

    task automatic rd_reg(input int a, input string tag);
        item_t it;
        @(negedge clk);
        smp_vld = 1'b0; smp_sync = 1'b0; buf_rd = 1'b0;
        reg_rd = 1'b1; reg_addr = 2'(a);
        it.kind = 0; it.addr = a; it.tag = tag;
        case (a)
            2: begin
                it.exp = lat_m[31:0]; hold_m = lat_m[63:32];
                it.exp2 = lat_s[31:0]; hold_s = lat_s[63:32];
            end
            3: begin it.exp = hold_m; it.exp2 = hold_s; end
            default: begin it.exp = '0; it.exp2 = '0; end
        endcase
        q.push_back(it);
    endtask

    task automatic rd_buf(input int a, input string tag);
        item_t it;
        @(negedge clk);
        smp_vld = 1'b0; smp_sync = 1'b0; reg_rd = 1'b0;
        buf_rd = 1'b1; buf_addr = 10'(a);
        it.kind = 1; it.addr = a; it.tag = tag;
        it.exp = {{16{ref_buf[a][15]}}, ref_buf[a]};
        it.exp2 = it.exp;
        q.push_back(it);
    endtask

    // monitor: compare one cycle after each strobe, away from the edge
    logic rr_q = 1'b0, br_q = 1'b0;
    always @(posedge clk) begin
        rr_q <= reg_rd;
        br_q <= buf_rd;
    end

    always @(negedge clk) begin
        if (rr_q || br_q) begin
            if (q.size() == 0) begin
                check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                item_t it;
                it = q.pop_front();
                if (it.kind == 0) begin
                    last_word[it.addr] = reg_rdata;
                    check(reg_rdata == it.exp, it.tag, reg_rdata, it.exp);
                    check(sat_rdata == it.exp2, {it.tag, " (34-bit)"}, sat_rdata, it.exp2);
                end else begin
                    check(buf_rdata == it.exp, it.tag, buf_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        real pw, ideal;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(reg_rdata == 0, "R1 reg_rdata at reset", reg_rdata, 0);
        check(buf_rdata == 0, "R1 buf_rdata at reset", buf_rdata, 0);
        rd_reg(2, "R1 power low after reset");
        rd_reg(3, "R1 power high after reset");
        rd_reg(0, "R4 reserved offset 0");
        rd_reg(1, "R4 reserved offset 1");

        // R2/R9: sine interval of 4096 valid samples, amplitude 8192, period 64, with gaps
        for (int k = 0; k < 4096; k++) begin
            if (k % 5 == 4) smp(1'b0, 1'b0, 16'h7FFF);  // R2: ignored data
            smp(1'b1, k == 0, 16'($rtoi($floor(8192.0 * $sin(6.283185307179586 * k / 64.0) + 0.5))));
        end
        // ramp interval: its sync latches the sine sum and restarts the capture
        for (int k = 0; k < 1500; k++) begin
            if (k % 9 == 8) smp(1'b0, 1'b1, 16'h1234); // R8: sync without valid
            smp(1'b1, k == 0, 16'(k * 7 - 3000));
        end
        rd_reg(2, "R2 sine power low");
        rd_reg(3, "R2 sine power high");
        idle(); idle();
        pw    = real'(last_word[3]) * 4294967296.0 + real'(last_word[2]);
        ideal = 8192.0 * 8192.0 / 2.0 * 4096.0;
        check((pw > 0.95 * ideal) && (pw < 1.05 * ideal), "R9 sine power within 5%",
              longint'(pw), longint'(ideal));

        // R5/R6/R7: the capture holds the first 1024 ramp samples, later ones excluded
        for (int a = 0; a < DEPTH; a++) rd_buf(a, "R5 R6 R7 capture word");

        // R8: invalid sync followed by samples must not restart capture or latch power
        smp(1'b0, 1'b1, 16'h0555);
        for (int k = 0; k < 5; k++) smp(1'b1, 1'b0, 16'(123 + k));
        rd_buf(0, "R8 capture word 0 unchanged");
        rd_buf(1, "R8 capture word 1 unchanged");
        rd_reg(2, "R8 power low unchanged");

        // R3: twenty full-scale negative samples
        smp(1'b1, 1'b1, 16'h8000);
        for (int k = 0; k < 19; k++) smp(1'b1, 1'b0, 16'h8000);
        smp(1'b1, 1'b1, 16'h0000);
        rd_reg(2, "R3 saturation low");
        rd_reg(3, "R3 saturation high");

        // R10: sync between low and high reads
        for (int k = 0; k < 30; k++) smp(1'b1, 1'b0, 16'h7FFF);
        rd_reg(2, "R10 low before sync");
        smp(1'b1, 1'b1, 16'h0001);
        rd_reg(3, "R10 high from saved copy");
        rd_reg(2, "R10 new low");
        rd_reg(3, "R10 new high");

        idle(); idle(); idle();
        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule